// File: doc/BRIEF.md
# Condition Code Register with Add/Subtract Flag Logic

This block holds the 8-bit processor status byte of a CPU datapath and the add/subtract flag logic that keeps it current. Each cycle it can take two operands, an operation code and an operand size (byte, word or long). It then returns the sized arithmetic result and loads the half-carry, negative, zero, overflow and carry flags from that operation. Software can also write the status byte directly, or merge it with an 8-bit immediate using AND, OR or XOR. All of these updates take one clock.

The top status bit is an interrupt mask. The block sets it whenever an exception sequence begins. While it is set, the block blocks every maskable interrupt request, but the non-maskable request always passes through. The byte can be read continuously. It is laid out as follows: bit 7 mask, bit 6 user, bit 5 half-carry H, bit 4 user, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Instruction decode, branch evaluation and interrupt priority are handled outside this block.

Top module: `ccr_unit`

## Requirements
- R1: After reset `ccr_q` reads 0x80: the mask bit (bit 7) is 1 and every other bit is 0.
- R2: When `sw_load` is high, `ccr_q` takes the value of `sw_imm` on the next clock edge.
- R3: When `sw_and`, `sw_or` or `sw_xor` is high, `ccr_q` is combined bitwise with `sw_imm` on the next edge. If several software strobes are high together, the priority is load > AND > OR > XOR.
- R4: When `exc_entry` is high, bit 7 of `ccr_q` is 1 on the next edge. This overrides any software write of that bit in the same cycle; the other bits follow their normal update.
- R5: `irq_pass` equals `irq_req` while bit 7 is 0 and is 0 while bit 7 is 1. `nmi_pass` always equals `nmi_req`. Bit 6 has no effect on either output.
- R6: Operand size code 0 = byte, 1 = word, 2 or 3 = long. H (bit 5) is the carry out of (or borrow from) bit 3, 11 or 27 respectively.
- R7: N (bit 3) is the most significant bit of the sized result: bit 7, 15 or 31. For non-extend operations, Z (bit 2) is 1 exactly when the sized result is zero.
- R8: Operation codes: 0 add, 1 add-extend, 2 subtract (a-b), 3 subtract-extend, 4 compare, 5 negate. V (bit 1) is signed overflow at the sized MSB. C (bit 0) is the carry out of, or borrow from, the sized MSB.
- R9: Add-extend adds the old C as a carry-in, and subtract-extend subtracts it as a borrow-in. For these two operations Z keeps its old value when the result is zero and is cleared when the result is nonzero.
- R10: Compare sets the flags exactly as subtract does, with `result_we` low. Negate returns 0 - b. `result` is zero-extended above the operand size. `result_we` is high when `op_valid` is high and the code is 0, 1, 2, 3 or 5.
- R11: A flag update changes only bits 5, 3, 2, 1 and 0. Any software strobe in the same cycle takes priority over the flag update. Codes 6 and 7 change no flag.
- R12: When no strobe, operation or exception entry is active, `ccr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform an arithmetic operation this cycle |
| op_sel | input | 3 | Operation code |
| op_size | input | 2 | Operand size code |
| src_a | input | 32 | First operand (minuend / augend) |
| src_b | input | 32 | Second operand (subtrahend / addend / negated value) |
| sw_load | input | 1 | Software load of the whole status byte |
| sw_and | input | 1 | AND the status byte with the immediate |
| sw_or | input | 1 | OR the status byte with the immediate |
| sw_xor | input | 1 | XOR the status byte with the immediate |
| sw_imm | input | 8 | Immediate for software writes |
| exc_entry | input | 1 | Start of exception handling |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| result | output | 32 | Sized result, zero-extended |
| result_we | output | 1 | Result should be written back |
| ccr_q | output | 8 | Current status byte |
| irq_pass | output | 1 | Maskable request after masking |
| nmi_pass | output | 1 | Non-maskable request passed through |

## Verification
The bench builds the block with its defaults: a 32-bit datapath and a reset value of 0x80. The 32-bit width makes all three operand sizes reachable. The reset value lets the first check see the mask bit come up set. With the long size reachable, the bench can drive carries across bit 27 and bit 31 as well as across the byte and word boundaries. The bench's model of the extend operations covers the sticky-zero behaviour in both directions, and its priority rules cover strobes that collide in the same cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned CCR_W = 8;

  // status byte bit positions (order matters to consumers of the byte)
  localparam int unsigned B_MASK = 7;
  localparam int unsigned B_USR1 = 6;
  localparam int unsigned B_HALF = 5;
  localparam int unsigned B_USR0 = 4;
  localparam int unsigned B_NEG  = 3;
  localparam int unsigned B_ZERO = 2;
  localparam int unsigned B_OVF  = 1;
  localparam int unsigned B_CRY  = 0;

  // operation codes
  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_ADDX = 3'd1;
  localparam logic [2:0] OPC_SUB  = 3'd2;
  localparam logic [2:0] OPC_SUBX = 3'd3;
  localparam logic [2:0] OPC_CMP  = 3'd4;
  localparam logic [2:0] OPC_NEG  = 3'd5;

  // size codes
  localparam logic [1:0] SZC_BYTE = 2'd0;
  localparam logic [1:0] SZC_WORD = 2'd1;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;

  // index of the sized most significant bit
  function automatic logic [5:0] sized_msb(input logic [1:0] sz);
    case (sz)
      SZC_BYTE: sized_msb = 6'd7;
      SZC_WORD: sized_msb = 6'd15;
      default:  sized_msb = 6'd31;
    endcase
  endfunction

  // all-ones mask covering bits msb..0 of a dw-bit word
  function automatic logic [63:0] low_ones(input logic [5:0] msb);
    low_ones = (64'd1 << (msb + 6'd1)) - 64'd1;
  endfunction

  function automatic logic op_is_sub(input logic [2:0] op);
    op_is_sub = (op == OPC_SUB) || (op == OPC_SUBX) ||
                (op == OPC_CMP) || (op == OPC_NEG);
  endfunction

  function automatic logic op_is_ext(input logic [2:0] op);
    op_is_ext = (op == OPC_ADDX) || (op == OPC_SUBX);
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    op_known = (op <= OPC_NEG);
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    op_writes = op_known(op) && (op != OPC_CMP);
  endfunction

endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          carry_in,
  input  logic          zero_in,
  output logic [DW-1:0] sum,
  output arith_flags_t  flags
);

  localparam int unsigned WW = DW + 1;

  logic [5:0]    msb;
  logic [5:0]    hbit;
  logic [DW-1:0] mask;
  logic [DW-1:0] hmask;
  logic [DW-1:0] am;
  logic [DW-1:0] bm;
  logic          do_sub;
  logic          ci;
  logic [WW-1:0] wide;
  logic [WW-1:0] half_wide;
  logic          a_s;
  logic          b_s;
  logic          r_s;
  logic          is_zero;

  always_comb begin
    msb    = sized_msb(size);
    hbit   = msb - 6'd4;
    mask   = DW'(low_ones(msb));
    hmask  = DW'(low_ones(hbit));
    do_sub = op_is_sub(op);
    ci     = op_is_ext(op) & carry_in;
    am     = (op == OPC_NEG) ? '0 : (opa & mask);
    bm     = opb & mask;
    if (do_sub) begin
      wide      = {1'b0, am} - {1'b0, bm} - WW'(ci);
      half_wide = {1'b0, am & hmask} - {1'b0, bm & hmask} - WW'(ci);
    end else begin
      wide      = {1'b0, am} + {1'b0, bm} + WW'(ci);
      half_wide = {1'b0, am & hmask} + {1'b0, bm & hmask} + WW'(ci);
    end
    sum     = wide[DW-1:0] & mask;
    a_s     = am[msb];
    b_s     = bm[msb];
    r_s     = sum[msb];
    is_zero = (sum == '0);
    flags.c = wide[msb + 6'd1];
    flags.h = half_wide[hbit + 6'd1];
    flags.n = r_s;
    flags.v = do_sub ? ((a_s != b_s) && (r_s != a_s))
                     : ((a_s == b_s) && (r_s != a_s));
    flags.z = op_is_ext(op) ? (zero_in & is_zero) : is_zero;
  end

endmodule

// File: rtl/ccr_store.sv
module ccr_store
  import ccr_pkg::*;
#(
  parameter logic [CCR_W-1:0] RESET_VAL = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_upd,
  input  arith_flags_t     flags,
  input  logic             sw_load,
  input  logic             sw_and,
  input  logic             sw_or,
  input  logic             sw_xor,
  input  logic [CCR_W-1:0] sw_imm,
  input  logic             force_mask,
  output logic [CCR_W-1:0] q
);

  logic [CCR_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (sw_load)      nxt = sw_imm;
    else if (sw_and)  nxt = q & sw_imm;
    else if (sw_or)   nxt = q | sw_imm;
    else if (sw_xor)  nxt = q ^ sw_imm;
    else if (flag_upd) begin
      nxt[B_HALF] = flags.h;
      nxt[B_NEG]  = flags.n;
      nxt[B_ZERO] = flags.z;
      nxt[B_OVF]  = flags.v;
      nxt[B_CRY]  = flags.c;
    end
    if (force_mask) nxt[B_MASK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= nxt;
  end

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
  input  logic mask_bit,
  input  logic irq_in,
  input  logic nmi_in,
  output logic irq_out,
  output logic nmi_out
);

  assign irq_out = irq_in & ~mask_bit;
  assign nmi_out = nmi_in;

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned      DW        = 32,
  parameter logic [CCR_W-1:0] RESET_CCR = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       op_size,
  input  logic [DW-1:0]    src_a,
  input  logic [DW-1:0]    src_b,
  input  logic             sw_load,
  input  logic             sw_and,
  input  logic             sw_or,
  input  logic             sw_xor,
  input  logic [CCR_W-1:0] sw_imm,
  input  logic             exc_entry,
  input  logic             irq_req,
  input  logic             nmi_req,
  output logic [DW-1:0]    result,
  output logic             result_we,
  output logic [CCR_W-1:0] ccr_q,
  output logic             irq_pass,
  output logic             nmi_pass
);

  // named internal events
  arith_flags_t alu_flags;
  logic         flag_upd;
  logic         sw_write;

  assign flag_upd  = op_valid & op_known(op_sel);
  assign sw_write  = sw_load | sw_and | sw_or | sw_xor;
  assign result_we = op_valid & op_writes(op_sel);

  ccr_alu #(.DW(DW)) u_alu (
    .op       (op_sel),
    .size     (op_size),
    .opa      (src_a),
    .opb      (src_b),
    .carry_in (ccr_q[B_CRY]),
    .zero_in  (ccr_q[B_ZERO]),
    .sum      (result),
    .flags    (alu_flags)
  );

  ccr_store #(.RESET_VAL(RESET_CCR)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_upd   (flag_upd),
    .flags      (alu_flags),
    .sw_load    (sw_load),
    .sw_and     (sw_and),
    .sw_or      (sw_or),
    .sw_xor     (sw_xor),
    .sw_imm     (sw_imm),
    .force_mask (exc_entry),
    .q          (ccr_q)
  );

  ccr_irq_gate u_gate (
    .mask_bit (ccr_q[B_MASK]),
    .irq_in   (irq_req),
    .nmi_in   (nmi_req),
    .irq_out  (irq_pass),
    .nmi_out  (nmi_pass)
  );

endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_sel,
  input logic       sw_load,
  input logic       sw_and,
  input logic       sw_or,
  input logic       sw_xor,
  input logic [7:0] sw_imm,
  input logic       exc_entry,
  input logic       irq_req,
  input logic       nmi_req,
  input logic       result_we,
  input logic [7:0] ccr_q,
  input logic       irq_pass,
  input logic       nmi_pass,
  input logic       flag_upd,
  input logic       sw_write
);

  // R5
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_q[7] |-> !irq_pass);

  // R5
  nmi_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pass == nmi_req);

  // R4
  exc_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> ccr_q[7]);

  // R2
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_load && !exc_entry) |=> ccr_q == $past(sw_imm));

  // R10
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 3'd4) |-> !result_we);

  // R11
  upd_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !sw_write && !exc_entry) |=>
      (ccr_q[7] == $past(ccr_q[7]) && ccr_q[6] == $past(ccr_q[6]) &&
       ccr_q[4] == $past(ccr_q[4])));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !sw_write && !exc_entry) |=> $stable(ccr_q));

endmodule

bind ccr_unit ccr_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .sw_load   (sw_load),
  .sw_and    (sw_and),
  .sw_or     (sw_or),
  .sw_xor    (sw_xor),
  .sw_imm    (sw_imm),
  .exc_entry (exc_entry),
  .irq_req   (irq_req),
  .nmi_req   (nmi_req),
  .result_we (result_we),
  .ccr_q     (ccr_q),
  .irq_pass  (irq_pass),
  .nmi_pass  (nmi_pass),
  .flag_upd  (flag_upd),
  .sw_write  (sw_write)
);

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        sw_load = 1'b0;
  logic        sw_and = 1'b0;
  logic        sw_or = 1'b0;
  logic        sw_xor = 1'b0;
  logic [7:0]  sw_imm = '0;
  logic        exc_entry = 1'b0;
  logic        irq_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [7:0]  ccr_q;
  logic        irq_pass;
  logic        nmi_pass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_ccr = 8'h80;
  logic [7:0] sb_val[$];
  string      sb_tag[$];

  always #10 clk = ~clk;   // 50 MHz

  ccr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .op_size(op_size), .src_a(src_a), .src_b(src_b), .sw_load(sw_load),
    .sw_and(sw_and), .sw_or(sw_or), .sw_xor(sw_xor), .sw_imm(sw_imm),
    .exc_entry(exc_entry), .irq_req(irq_req), .nmi_req(nmi_req),
    .result(result), .result_we(result_we), .ccr_q(ccr_q),
    .irq_pass(irq_pass), .nmi_pass(nmi_pass)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint sgn(input longint unsigned x, input int w);
    longint unsigned half = 64'd1 << (w - 1);
    sgn = (x >= half) ? longint'(x) - longint'(64'd1 << w) : longint'(x);
  endfunction

  // independent model of the arithmetic, written from the requirements
  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [7:0] cc, output logic [31:0] r,
                                output logic [7:0] nc, output logic we);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint unsigned mk = (64'd1 << w) - 1;
    longint unsigned hm = (64'd1 << (w - 4)) - 1;
    longint unsigned ua = a & mk;
    longint unsigned ub = b & mk;
    longint unsigned ci = ((op == 3'd1) || (op == 3'd3)) ? longint'(cc[0]) : 0;
    longint unsigned s;
    longint sv;
    logic c, h, v, n, z;
    nc = cc;
    we = (op <= 3'd5) && (op != 3'd4);
    if (op == 3'd5) ua = 0;
    if (op == 3'd0 || op == 3'd1) begin
      s  = ua + ub + ci;
      c  = ((s >> w) & 1) != 0;
      h  = ((((ua & hm) + (ub & hm) + ci) >> (w - 4)) & 1) != 0;
      sv = sgn(ua, w) + sgn(ub, w) + longint'(ci);
    end else begin
      s  = ua - ub - ci;
      c  = ua < ub + ci;
      h  = (ua & hm) < (ub & hm) + ci;
      sv = sgn(ua, w) - sgn(ub, w) - longint'(ci);
    end
    s = s & mk;
    r = 32'(s);
    v = (sv > longint'((64'd1 << (w - 1)) - 1)) || (sv < -longint'(64'd1 << (w - 1)));
    n = ((s >> (w - 1)) & 1) != 0;
    z = (s == 0);
    if (op == 3'd1 || op == 3'd3) z = z & cc[2];
    if (op <= 3'd5) begin
      nc[5] = h; nc[3] = n; nc[2] = z; nc[1] = v; nc[0] = c;
    end
  endfunction

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit vld, input logic [2:0] op, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit ld, input bit an, input bit orr, input bit xr,
                      input logic [7:0] imm, input bit ex, input string tag);
    logic [31:0] er;
    logic [7:0]  nc;
    logic        ew;
    @(negedge clk);
    op_valid = vld; op_sel = op; op_size = sz; src_a = a; src_b = b;
    sw_load = ld; sw_and = an; sw_or = orr; sw_xor = xr; sw_imm = imm;
    exc_entry = ex;
    #2;
    model(op, sz, a, b, exp_ccr, er, nc, ew);
    if (vld) begin
      chk(result_we == ew, {tag, " result_we"}, result_we, ew);
      if (ew) chk(result == er, {tag, " result"}, result, er);
    end
    if (!vld) nc = exp_ccr;
    if (ld)       nc = imm;
    else if (an)  nc = exp_ccr & imm;
    else if (orr) nc = exp_ccr | imm;
    else if (xr)  nc = exp_ccr ^ imm;
    if (ex) nc[7] = 1'b1;
    exp_ccr = nc;
    sb_val.push_back(nc);
    sb_tag.push_back(tag);
    @(posedge clk);
    #1;
    op_valid = 0; sw_load = 0; sw_and = 0; sw_or = 0; sw_xor = 0; exc_entry = 0;
  endtask

  task automatic arith(input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    step(1, op, sz, a, b, 0, 0, 0, 0, 8'h00, 0, tag);
  endtask

  task automatic load(input logic [7:0] v, input string tag);
    step(0, 3'd0, 2'd0, 0, 0, 1, 0, 0, 0, v, 0, tag);
  endtask

  task automatic irq_chk(input bit ir, input bit nm, input string tag);
    @(negedge clk);
    irq_req = ir; nmi_req = nm;
    #2;
    chk(irq_pass == (ir & ~exp_ccr[7]), {tag, " irq_pass"}, irq_pass, ir & ~exp_ccr[7]);
    chk(nmi_pass == nm, {tag, " nmi_pass"}, nmi_pass, nm);
  endtask

  // monitor: pop expected status bytes as the design produces them
  always @(posedge clk) begin
    #1;
    if (sb_val.size() != 0) begin
      logic [7:0] e;
      string t;
      e = sb_val.pop_front();
      t = sb_tag.pop_front();
      chk(ccr_q == e, {t, " ccr"}, ccr_q, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(ccr_q == 8'h80, "R1 reset value", ccr_q, 8'h80);
    rst_n = 1'b1;
    irq_chk(1, 0, "R5 masked irq");
    irq_chk(1, 1, "R5 nmi under mask");
    load(8'h00, "R2 load zero");
    irq_chk(1, 0, "R5 unmasked irq");
    load(8'h40, "R2 load user bit6");
    irq_chk(1, 1, "R5 bit6 no masking");
    irq_chk(0, 0, "R5 idle");
    load(8'hA5, "R2 load A5");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h3C, 0, "R3 and");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hC1, 0, "R3 or");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, "R3 xor");
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 8'h5A, 0, "R3 priority load");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 8'h0F, 0, "R3 priority and over or");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h00, 1, "R4 exception over load");
    irq_chk(1, 0, "R4 R5 after exception");
    load(8'h00, "R2 clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, "R4 exception alone");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R12 idle hold");
    load(8'h50, "R2 user bits set");
    arith(3'd0, 2'd0, 32'h0F, 32'h01, "R6 byte half carry");
    arith(3'd0, 2'd0, 32'h7F, 32'h01, "R8 byte overflow");
    arith(3'd0, 2'd0, 32'hFF, 32'h01, "R7 byte zero carry");
    arith(3'd0, 2'd1, 32'h0FFF, 32'h0001, "R6 word half carry");
    arith(3'd0, 2'd1, 32'h8000, 32'h8000, "R8 word overflow carry");
    arith(3'd0, 2'd2, 32'h0FFF_FFFF, 32'h1, "R6 long half carry");
    arith(3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, "R7 long zero carry");
    arith(3'd0, 2'd0, 32'hFFFF_FF00, 32'h0000_0180, "R10 sized zero extend");
    arith(3'd2, 2'd0, 32'h10, 32'h01, "R6 byte half borrow");
    arith(3'd2, 2'd0, 32'h00, 32'h01, "R8 byte borrow");
    arith(3'd2, 2'd1, 32'h8000, 32'h0001, "R8 word sub overflow");
    arith(3'd2, 2'd2, 32'h1000_0000, 32'h1, "R6 long half borrow");
    load(8'h05, "R9 prep z c");
    arith(3'd3, 2'd0, 32'h01, 32'h00, "R9 subx zero keeps z");
    load(8'h01, "R9 prep c only");
    arith(3'd3, 2'd0, 32'h01, 32'h00, "R9 subx zero z stays clear");
    load(8'h05, "R9 prep z c again");
    arith(3'd1, 2'd1, 32'h0001, 32'h0001, "R9 addx nonzero clears z");
    load(8'h01, "R9 prep c");
    arith(3'd1, 2'd2, 32'hFFFF_FFFE, 32'h1, "R9 addx long carry in");
    arith(3'd4, 2'd1, 32'h1234, 32'h1234, "R10 compare equal");
    arith(3'd4, 2'd0, 32'h01, 32'h80, "R10 compare overflow");
    arith(3'd5, 2'd0, 32'hAB, 32'h01, "R10 negate byte");
    arith(3'd5, 2'd2, 32'h0, 32'h8000_0000, "R10 negate long min");
    arith(3'd6, 2'd0, 32'h01, 32'h01, "R11 unused code 6");
    arith(3'd7, 2'd1, 32'h01, 32'h01, "R11 unused code 7");
    step(1, 3'd0, 2'd0, 32'hFF, 32'h01, 1, 0, 0, 0, 8'h42, 0, "R11 load beats update");
    step(1, 3'd2, 2'd0, 32'h00, 32'h01, 0, 0, 1, 0, 8'h10, 0, "R11 or beats update");
    step(1, 3'd0, 2'd0, 32'h7F, 32'h01, 0, 0, 0, 0, 8'h00, 1, "R4 exception with update");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R12 final hold");
    repeat (3) @(negedge clk);
    chk(sb_val.size() == 0, "scoreboard drained", sb_val.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule